// File: doc/BRIEF.md
# Power-Fail Early-Warning Interrupt Generator

This block gives a processor advance notice that an upstream supply is about to fail. An external comparator watches a sense point taken from the monitored supply. Its output reaches this block as `sense_ok`, which is high while the supply is above its trip level. The signal is not yet synchronised. The block also receives `vcc_ok`, a synchronous flag that is high once the local supply has reached its own trip level.

The block brings the sense flag into the clock domain with a two-flop synchroniser. A persistence counter then filters it, so that supply noise cannot raise a false interrupt. When the low reading lasts long enough, a one-shot timer drives the active-low `irq_n` for a fixed number of cycles. The block issues one pulse per supply dip. The generator arms again only after the sense point has been seen above its level once more. While `vcc_ok` is low, as during power-up, low sense readings are ignored altogether.

The pulse comes from a register and has a fixed width. It can therefore feed the pushbutton input of a reset sequencer directly, so that a failing sense point forces a full reset.

Top module: `pfail_warn`

## Requirements
- R1: While `rst_n` is low, and after its release while `sense_ok` stays high, `irq_n` is held high.
- R2: When `sense_ok` falls and stays low, `irq_n` goes low exactly PERSIST_CYC+2 cycles later. Two cycles are the synchroniser; the rest are the persistence count and the output register.
- R3: A low on `sense_ok` lasting PERSIST_CYC-1 cycles or less produces no pulse. A low lasting PERSIST_CYC cycles produces one.
- R4: Once started, `irq_n` stays low for exactly PULSE_CYC cycles. It stays low for that long even if `sense_ok` returns high during the pulse.
- R5: While `sense_ok` stays low after a pulse, no further pulse is issued.
- R6: After the synchronised sense input has been seen high following a pulse, a new qualified low produces a new pulse.
- R7: While `vcc_ok` is low, no persistence is counted and `irq_n` stays high. If `sense_ok` is still low when `vcc_ok` rises, `irq_n` falls exactly PERSIST_CYC cycles after that rise.
- R8: A single low cycle of `vcc_ok` during the persistence window restarts the count in full.
- R9: Each pulse has exactly one falling edge and lasts long enough to satisfy a reset sequencer's pushbutton debounce placed on `irq_n`.
- R10: `vcc_ok` falling during a pulse does not shorten the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_ok | input | 1 | Asynchronous comparator flag, high while the upstream supply is above its trip level |
| vcc_ok | input | 1 | Synchronous flag, high once the local supply has reached its trip level |
| irq_n | output | 1 | Active-low early-warning interrupt pulse |

## Verification
Faults inside the block show up at `irq_n` quickly, because the pulse's start and length are counted exactly.

- A persistence counter that does not clear, or that counts through a low on `vcc_ok`, moves the falling edge earlier than the PERSIST_CYC+2 or PERSIST_CYC latency. The bench sees this on the first qualified event.
- A pulse timer that is off by one changes the low width as soon as the first pulse ends.
- A one-shot state that fails to stay spent shows up as a second falling edge within one PULSE_CYC window while the sense input is still low.
- A one-shot state that never re-arms shows up as a missing pulse on the next dip.

// File: rtl/pfw_pkg.sv
// Package: shared types for the power-fail early-warning generator.
// Assumes nothing beyond the parameters passed to the modules that use it.
package pfw_pkg;

    // States of the one-shot pulse generator.
    typedef enum logic [1:0] {
        OS_ARMED = 2'd0,   // waiting for a qualified low
        OS_PULSE = 2'd1,   // driving the interrupt low
        OS_SPENT = 2'd2    // pulse done, waiting for the sense input to recover
    } os_state_t;

    // Width of a counter that must hold values 0..n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pfw_sync.sv
// Module: pfw_sync
// Multi-stage flop synchroniser for a single-bit asynchronous level.
// Assumes: the input is a slow level, so metastability settles within one stage.
// The reset value is a parameter, so the output reads "safe" during reset.
module pfw_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Capture the asynchronous level in one stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d_async;
            end
        end else begin : g_chain
            // Shift the asynchronous level through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pfw_persist.sv
// Module: pfw_persist
// Persistence filter. It counts consecutive cycles in which the synchronised
// sense reading is low while the local supply is in tolerance. The trip
// output is high from the cycle in which the count reaches PERSIST_CYC-1 and
// stays high while the low persists, because the count saturates there.
// Any high sense cycle or low vcc_ok cycle clears the count.
// Assumes: PERSIST_CYC >= 2; vcc_ok is already synchronous to clk.
module pfw_persist
    import pfw_pkg::*;
#(
    parameter int PERSIST_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_low,
    input  logic vcc_ok,
    output logic trip
);

    localparam int CW = cnt_width(PERSIST_CYC);
    localparam logic [CW-1:0] LAST = CW'(PERSIST_CYC - 1);

    logic [CW-1:0] cnt;
    logic          qual;

    assign qual = sense_low & vcc_ok;

    // Count qualified low cycles, saturating at LAST; clear on any break.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!qual)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + CW'(1);
    end

    assign trip = qual && (cnt == LAST);

endmodule

// File: rtl/pfw_oneshot.sv
// Module: pfw_oneshot
// One-shot pulse generator. A trip while armed starts a low pulse on irq_n
// that lasts exactly PULSE_CYC cycles, whatever the inputs do meanwhile.
// After the pulse the generator stays spent until the synchronised sense
// input reads high. This gives one pulse per supply dip.
// Assumes: PULSE_CYC >= 2; trip and sense_hi are synchronous to clk.
module pfw_oneshot
    import pfw_pkg::*;
#(
    parameter int PULSE_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic sense_hi,
    output logic irq_n
);

    localparam int TW = cnt_width(PULSE_CYC);
    localparam logic [TW-1:0] TLAST = TW'(PULSE_CYC - 1);

    os_state_t     state;
    logic [TW-1:0] tmr;

    // Sequence armed -> pulse -> spent -> armed and drive the registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OS_ARMED;
            tmr   <= '0;
            irq_n <= 1'b1;
        end else begin
            case (state)
                OS_ARMED: begin
                    if (trip) begin
                        state <= OS_PULSE;
                        tmr   <= '0;
                        irq_n <= 1'b0;
                    end
                end
                OS_PULSE: begin
                    if (tmr == TLAST) begin
                        state <= OS_SPENT;
                        irq_n <= 1'b1;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                OS_SPENT: begin
                    if (sense_hi) state <= OS_ARMED;
                end
                default: begin
                    state <= OS_ARMED;
                    irq_n <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfail_warn.sv
// Module: pfail_warn (top)
// Power-fail early-warning interrupt generator. It synchronises the upstream
// comparator flag, filters it for persistence (gated by the local supply
// flag) and emits one fixed-width active-low pulse per qualified dip.
// Assumes: sense_ok is asynchronous; vcc_ok is synchronous to clk;
// PERSIST_CYC >= 2 and PULSE_CYC >= 2.
module pfail_warn #(
    parameter int PERSIST_CYC = 250,
    parameter int PULSE_CYC   = 10000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_ok,
    input  logic vcc_ok,
    output logic irq_n
);

    logic sense_sync;
    logic trip;

    pfw_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sense_ok),
        .q_sync  (sense_sync)
    );

    pfw_persist #(
        .PERSIST_CYC (PERSIST_CYC)
    ) u_persist (
        .clk       (clk),
        .rst_n     (rst_n),
        .sense_low (~sense_sync),
        .vcc_ok    (vcc_ok),
        .trip      (trip)
    );

    pfw_oneshot #(
        .PULSE_CYC (PULSE_CYC)
    ) u_oneshot (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip     (trip),
        .sense_hi (sense_sync),
        .irq_n    (irq_n)
    );

endmodule

// File: rtl/pfail_warn_chk.sv
// Module: pfail_warn_chk
// Port-level checker for pfail_warn, attached by bind. It tracks the length
// of each low run on irq_n and whether the sense input has been high since
// the last falling edge.
module pfail_warn_chk #(
    parameter int PERSIST_CYC = 250,
    parameter int PULSE_CYC   = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic sense_ok,
    input logic vcc_ok,
    input logic irq_n
);

    localparam int LW = $clog2(PULSE_CYC + 2) + 1;

    logic [LW-1:0] low_run;
    logic          irq_q;
    logic          seen_hi;

    // Count consecutive low cycles of the interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n)      low_run <= '0;
        else if (!irq_n) low_run <= low_run + LW'(1);
        else             low_run <= '0;
    end

    // Remember whether the sense input was high since the last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b1;
            seen_hi <= 1'b1;
        end else begin
            irq_q <= irq_n;
            if (irq_q && !irq_n) seen_hi <= 1'b0;
            else if (sense_ok)   seen_hi <= 1'b1;
        end
    end

    assert_reset_high_R1: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    assert_persist_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> !$past(sense_ok, 3));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> (low_run == LW'(PULSE_CYC)));

    assert_no_long_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (low_run < LW'(PULSE_CYC)));

    assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(seen_hi));

    assert_vcc_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(vcc_ok));

endmodule

bind pfail_warn pfail_warn_chk #(
    .PERSIST_CYC (PERSIST_CYC),
    .PULSE_CYC   (PULSE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sense_ok (sense_ok),
    .vcc_ok   (vcc_ok),
    .irq_n    (irq_n)
);

// File: tb/tb_pfail_warn.sv
// Bench for pfail_warn: a table of dip lengths walked by one loop, then
// directed tests for reset, power-up gating, count restart and supply loss
// during a pulse. A pushbutton-debounce model watches irq_n for R9.
module tb_pfail_warn;

    localparam int P      = 8;    // persistence cycles
    localparam int W      = 40;   // pulse width cycles
    localparam int PB_MIN = 30;   // pushbutton debounce threshold of the reset model
    localparam int NCASE  = 5;

    localparam int LEN_TAB  [NCASE] = '{1, P-1, P, 12, 100};
    localparam bit FIRE_TAB [NCASE] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_ok = 1'b1;
    logic vcc_ok = 1'b1;
    logic irq_n;

    int errors = 0;
    int checks = 0;

    int first_low, low_cnt, falls;
    bit pb_hit;

    always #10 clk = ~clk;   // 50 MHz

    pfail_warn #(
        .PERSIST_CYC (P),
        .PULSE_CYC   (W),
        .SYNC_STAGES (2)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sense_ok (sense_ok),
        .vcc_ok   (vcc_ok),
        .irq_n    (irq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample irq_n on each of `win` negedges and apply the scheduled input
    // changes after sampling (index 0 means never).
    task automatic observe(input int win, input int hi_at, input int vlo_at, input int vhi_at);
        int pb_cnt = 0;
        logic prev = 1'b1;
        first_low = 0; low_cnt = 0; falls = 0; pb_hit = 1'b0;
        for (int i = 1; i <= win; i++) begin
            @(negedge clk);
            if (!irq_n) begin
                low_cnt++;
                pb_cnt++;
                if (first_low == 0) first_low = i;
                if (prev) falls++;
            end else begin
                pb_cnt = 0;
            end
            if (pb_cnt >= PB_MIN) pb_hit = 1'b1;
            prev = irq_n;
            if (i == hi_at)  sense_ok = 1'b1;
            if (i == vlo_at) vcc_ok = 1'b0;
            if (i == vhi_at) vcc_ok = 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (5) @(negedge clk);
        check(irq_n === 1'b1, "R1 irq_n during reset", irq_n, 1);
        rst_n = 1'b1;
        observe(20, 0, 0, 0);
        check(low_cnt == 0, "R1 idle after reset", low_cnt, 0);

        // Table of dip lengths: R2, R3, R4, R5, R6, R9
        for (int c = 0; c < NCASE; c++) begin
            sense_ok = 1'b0;
            observe(LEN_TAB[c] + P + W + 10, LEN_TAB[c], 0, 0);
            check((low_cnt > 0) == FIRE_TAB[c], $sformatf("R3 fire for dip %0d", LEN_TAB[c]),
                  int'(low_cnt > 0), int'(FIRE_TAB[c]));
            if (FIRE_TAB[c]) begin
                check(first_low == P + 2, "R2 latency", first_low, P + 2);
                check(low_cnt == W, "R4 width", low_cnt, W);
                check(falls == 1, "R5 single fall per dip", falls, 1);
                check(pb_hit, "R9 pushbutton model reset", int'(pb_hit), 1);
                if (c > 2) check(falls == 1, "R6 re-armed pulse", falls, 1);
            end else begin
                check(!pb_hit, "R9 no pushbutton reset", int'(pb_hit), 0);
            end
        end

        // R7: power-up gating, then pulse PERSIST cycles after vcc_ok rises
        vcc_ok = 1'b0;
        sense_ok = 1'b0;
        observe(50, 0, 0, 0);
        check(low_cnt == 0, "R7 no pulse while vcc_ok low", low_cnt, 0);
        vcc_ok = 1'b1;
        observe(P + W + 20, P + W + 5, 0, 0);
        check(first_low == P, "R7 latency after vcc_ok rise", first_low, P);
        check(low_cnt == W, "R7 width", low_cnt, W);

        // R8: one low vcc_ok cycle mid-persistence restarts the count
        sense_ok = 1'b0;
        observe(P + W + 30, P + W + 20, 5, 6);
        check(first_low == P + 6, "R8 restart latency", first_low, P + 6);
        check(low_cnt == W, "R8 width", low_cnt, W);

        // R10: vcc_ok lost during the pulse does not shorten it
        sense_ok = 1'b0;
        observe(P + W + 30, P + W + 20, P + 5, P + W + 15);
        check(first_low == P + 2, "R10 latency", first_low, P + 2);
        check(low_cnt == W, "R10 width with vcc_ok low", low_cnt, W);
        check(falls == 1, "R10 single fall", falls, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule